// File: doc/BRIEF.md
# Background Tile Fetcher

This block fetches one row of eight background or window pixels for a scanline renderer. It reads a tile number from one of two 1 KiB tile maps in video memory and turns that number into a tile-data address for the current pixel row. It then reads the two bit-plane bytes of that row and interleaves them into eight 4-bit pixel codes. The result is a 32-bit word, and a one-cycle strobe marks when it is ready.

A fixed eight-step sequence drives the work. The step counter moves forward on each clock that has `advance` high, and a `restart` pulse sends it back to step 0 and discards any fetch in progress. Video memory is read through a synchronous port. An address and read strobe issued on one clock return data on the following clock. In window mode the map coordinates are offset by the window position rather than the scroll registers, and every pixel carries a tag bit.

Top module: `bg_tile_fetch`

## Requirements
- R1: While reset is asserted, `row_ready` is 0, `row_pixels` is 0 and `vram_rd` is 0.
- R2: In background mode the map column is `(fetch_x + scroll_x) mod 256` and the map row is `(line_y + scroll_y) mod 256`. The map entry address is map base + (row/8)·32 + column/8, and it is presented at step 0 with `vram_rd` high.
- R3: In window mode the map column is `(fetch_x − win_x) mod 256` and the map row is `(line_y − win_y_latched) mod 256`.
- R4: `bg_map_sel` chooses the map in background mode and `win_map_sel` chooses it in window mode. A select bit of 1 places the map at 0x1800 and a select bit of 0 places it at 0x1C00. The other select bit has no effect.
- R5: With `data_area_sel` = 1, the tile-data address is tile·16 + 2·(map row mod 8), where the tile number is unsigned.
- R6: With `data_area_sel` = 0, the tile-data address is 0x1000 + signed(tile)·16 + 2·(map row mod 8), taken modulo 2^13.
- R7: The low plane is read at that address at step 2 and the high plane is read at that address + 1 at step 4.
- R8: Pixel i, counted from the left, occupies bits [31−4i : 28−4i]. Within that slot, bit 1 is bit 7−i of the high plane and bit 0 is bit 7−i of the low plane. `row_pixels` changes only together with `row_ready`.
- R9: Bit 2 of every slot is 1 for a window fetch and 0 for a background fetch. Bit 3 of every slot is always 0.
- R10: `vram_rd` is high only on advancing cycles at steps 0, 2 and 4. `row_ready` is a single-cycle pulse on the cycle after step 5 advances. With `advance` held high, the step counter wraps and a new fetch gives another pulse 8 cycles later.
- R11: `restart` sets the step to 0 on the next clock and discards the fetch in progress. No pulse comes from the dropped fetch.
- R12: On a cycle with `advance` low and no restart, the step does not change, no read is issued and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| restart | input | 1 | Return to step 0 and discard the current fetch |
| advance | input | 1 | Step enable |
| win_mode | input | 1 | 1 selects a window fetch, 0 selects a background fetch |
| scroll_x | input | 8 | Background horizontal scroll |
| scroll_y | input | 8 | Background vertical scroll |
| line_y | input | 8 | Current scanline |
| win_x | input | 8 | Window horizontal position |
| win_y_latched | input | 8 | Window vertical position captured for the line |
| fetch_x | input | 8 | Horizontal fetch position |
| bg_map_sel | input | 1 | Map choice for background fetches |
| win_map_sel | input | 1 | Map choice for window fetches |
| data_area_sel | input | 1 | 1 selects unsigned tile addressing, 0 selects signed tile addressing |
| vram_rd | output | 1 | Read strobe to video memory |
| vram_addr | output | 13 | Video memory byte address |
| vram_rdata | input | 8 | Read data, valid on the clock after the strobe |
| row_pixels | output | 32 | Eight 4-bit pixel codes, leftmost pixel in the top slot |
| row_ready | output | 1 | One-cycle strobe marking a new row |

## Verification
After a restart, the step counter reads 0 on the following clock. From that point the map address is due straight away, the low-plane address two advancing edges later, and the high-plane address four advancing edges later. The pixel row and its strobe are due on the sixth advancing edge, because the last plane byte comes back on step 5 and is registered into the output. The bench drives every input on the falling edge and counts rising edges up to each of those points. It samples on the falling edge, and when it inserts a stall it adds the stall cycles to the count. With `advance` held high, the next strobe is expected eight edges after the previous one.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int STEP_W = 3;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t ST_MAP_RD  = 3'd0;
  localparam step_t ST_MAP_CAP = 3'd1;
  localparam step_t ST_LO_RD   = 3'd2;
  localparam step_t ST_LO_CAP  = 3'd3;
  localparam step_t ST_HI_RD   = 3'd4;
  localparam step_t ST_HI_CAP  = 3'd5;

  localparam int SLOT_W = 4;
  localparam int SLOT_LO_BIT  = 0;
  localparam int SLOT_HI_BIT  = 1;
  localparam int SLOT_TAG_BIT = 2;
endpackage

// File: rtl/bgf_step_seq.sv
module bgf_step_seq
  import bgf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  advance,
  output step_t step
);
  step_t step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (restart)      step_d = ST_MAP_RD;
    else if (advance) step_d = step_q + step_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_MAP_RD;
    else        step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen #(
  parameter int COORD_W  = 8,
  parameter int TILE_W   = 8,
  parameter int ADDR_W   = 13,
  parameter int TILE_PX  = 8,
  parameter int MAP_COLS = 32,
  parameter int BYTES_PER_TILE = 16,
  parameter int BYTES_PER_ROW  = 2,
  parameter logic [ADDR_W-1:0] MAP_SET_BASE = 13'h1800,
  parameter logic [ADDR_W-1:0] MAP_CLR_BASE = 13'h1C00,
  parameter logic [ADDR_W-1:0] SIGNED_BASE  = 13'h1000,
  localparam int ROW_BITS = $clog2(TILE_PX)
) (
  input  logic                win_mode,
  input  logic [COORD_W-1:0]  scroll_x,
  input  logic [COORD_W-1:0]  scroll_y,
  input  logic [COORD_W-1:0]  line_y,
  input  logic [COORD_W-1:0]  win_x,
  input  logic [COORD_W-1:0]  win_y,
  input  logic [COORD_W-1:0]  fetch_x,
  input  logic                bg_map_sel,
  input  logic                win_map_sel,
  output logic [ADDR_W-1:0]   map_addr,
  output logic [ROW_BITS-1:0] line_in_tile,
  input  logic [TILE_W-1:0]   tile,
  input  logic [ROW_BITS-1:0] row_sel,
  input  logic                data_area_sel,
  output logic [ADDR_W-1:0]   data_base
);
  localparam int TILE_SHIFT = $clog2(BYTES_PER_TILE);
  localparam int ROW_SHIFT  = $clog2(BYTES_PER_ROW);

  logic [COORD_W-1:0] map_col, map_row;
  logic               map_pick;
  logic [ADDR_W-1:0]  map_index;
  logic [ADDR_W-1:0]  tile_u, tile_s, row_off;

  always_comb begin
    if (win_mode) begin
      map_col  = fetch_x - win_x;
      map_row  = line_y - win_y;
      map_pick = win_map_sel;
    end else begin
      map_col  = fetch_x + scroll_x;
      map_row  = line_y + scroll_y;
      map_pick = bg_map_sel;
    end
    map_index = ADDR_W'(map_row[COORD_W-1:ROW_BITS]) * ADDR_W'(MAP_COLS)
              + ADDR_W'(map_col[COORD_W-1:ROW_BITS]);
    map_addr  = (map_pick ? MAP_SET_BASE : MAP_CLR_BASE) + map_index;
    line_in_tile = map_row[ROW_BITS-1:0];
  end

  always_comb begin
    tile_u  = ADDR_W'(tile);
    tile_s  = {{(ADDR_W-TILE_W){tile[TILE_W-1]}}, tile};
    row_off = ADDR_W'(row_sel) << ROW_SHIFT;
    if (data_area_sel) data_base = (tile_u << TILE_SHIFT) + row_off;
    else               data_base = SIGNED_BASE + (tile_s << TILE_SHIFT) + row_off;
  end
endmodule

// File: rtl/bgf_row_pack.sv
module bgf_row_pack
  import bgf_pkg::*;
#(
  parameter int PIX = 8,
  localparam int ROW_W = PIX * SLOT_W
) (
  input  logic [PIX-1:0]   plane_lo,
  input  logic [PIX-1:0]   plane_hi,
  input  logic             tag,
  output logic [ROW_W-1:0] row
);
  for (genvar i = 0; i < PIX; i++) begin : g_slot
    localparam int SLOT = PIX - 1 - i;
    localparam int SRC  = PIX - 1 - i;
    logic [SLOT_W-1:0] code;
    always_comb begin
      code = '0;
      code[SLOT_LO_BIT]  = plane_lo[SRC];
      code[SLOT_HI_BIT]  = plane_hi[SRC];
      code[SLOT_TAG_BIT] = tag;
    end
    assign row[SLOT*SLOT_W +: SLOT_W] = code;
  end
endmodule

// File: rtl/bg_tile_fetch.sv
module bg_tile_fetch
  import bgf_pkg::*;
#(
  parameter int COORD_W = 8,
  parameter int TILE_W  = 8,
  parameter int ADDR_W  = 13,
  parameter int TILE_PX = 8,
  localparam int ROW_BITS = $clog2(TILE_PX),
  localparam int ROW_W    = TILE_PX * SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               advance,
  input  logic               win_mode,
  input  logic [COORD_W-1:0] scroll_x,
  input  logic [COORD_W-1:0] scroll_y,
  input  logic [COORD_W-1:0] line_y,
  input  logic [COORD_W-1:0] win_x,
  input  logic [COORD_W-1:0] win_y_latched,
  input  logic [COORD_W-1:0] fetch_x,
  input  logic               bg_map_sel,
  input  logic               win_map_sel,
  input  logic               data_area_sel,
  output logic               vram_rd,
  output logic [ADDR_W-1:0]  vram_addr,
  input  logic [TILE_W-1:0]  vram_rdata,
  output logic [ROW_W-1:0]   row_pixels,
  output logic               row_ready
);
  logic rst_meta, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  step_t step_q;
  logic  step_en;

  assign step_en = advance & rst_core_n;

  bgf_step_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (restart),
    .advance (step_en),
    .step    (step_q)
  );

  logic [ADDR_W-1:0]   map_addr, data_base;
  logic [ROW_BITS-1:0] line_in_tile;

  logic                win_q, win_d;
  logic [ROW_BITS-1:0] line_q, line_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [TILE_W-1:0]   lo_q, lo_d;
  logic [ROW_W-1:0]    pix_q, pix_d, packed_row;
  logic                rdy_q, rdy_d;

  bgf_addr_gen #(
    .COORD_W (COORD_W),
    .TILE_W  (TILE_W),
    .ADDR_W  (ADDR_W),
    .TILE_PX (TILE_PX)
  ) u_addr (
    .win_mode      (win_mode),
    .scroll_x      (scroll_x),
    .scroll_y      (scroll_y),
    .line_y        (line_y),
    .win_x         (win_x),
    .win_y         (win_y_latched),
    .fetch_x       (fetch_x),
    .bg_map_sel    (bg_map_sel),
    .win_map_sel   (win_map_sel),
    .map_addr      (map_addr),
    .line_in_tile  (line_in_tile),
    .tile          (vram_rdata),
    .row_sel       (line_q),
    .data_area_sel (data_area_sel),
    .data_base     (data_base)
  );

  bgf_row_pack #(.PIX(TILE_PX)) u_pack (
    .plane_lo (lo_q),
    .plane_hi (vram_rdata),
    .tag      (win_q),
    .row      (packed_row)
  );

  logic go;
  assign go = step_en & ~restart;

  always_comb begin
    win_d  = win_q;
    line_d = line_q;
    base_d = base_q;
    lo_d   = lo_q;
    pix_d  = pix_q;
    rdy_d  = 1'b0;
    if (go) begin
      case (step_q)
        ST_MAP_RD: begin
          win_d  = win_mode;
          line_d = line_in_tile;
        end
        ST_MAP_CAP: base_d = data_base;
        ST_LO_CAP:  lo_d   = vram_rdata;
        ST_HI_CAP: begin
          pix_d = packed_row;
          rdy_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      win_q  <= 1'b0;
      line_q <= '0;
      base_q <= '0;
      lo_q   <= '0;
      pix_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      win_q  <= win_d;
      line_q <= line_d;
      base_q <= base_d;
      lo_q   <= lo_d;
      pix_q  <= pix_d;
      rdy_q  <= rdy_d;
    end
  end

  always_comb begin
    case (step_q)
      ST_MAP_RD: vram_addr = map_addr;
      ST_HI_RD:  vram_addr = base_q + ADDR_W'(1);
      default:   vram_addr = base_q;
    endcase
    vram_rd = go & ((step_q == ST_MAP_RD) | (step_q == ST_LO_RD) | (step_q == ST_HI_RD));
  end

  assign row_pixels = pix_q;
  assign row_ready  = rdy_q;
endmodule

// File: rtl/bgf_checker.sv
module bgf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        advance,
  input logic [2:0]  step,
  input logic        vram_rd,
  input logic [12:0] vram_addr,
  input logic [31:0] row_pixels,
  input logic        row_ready
);
  assert_read_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |=> !vram_rd);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    row_ready |=> !row_ready);

  assert_restart_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (step == 3'd0 && !row_ready));

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> ($stable(step) && !row_ready));

  assert_hi_plane_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_rd && step == 3'd4) |-> vram_addr[0]);

  assert_lo_plane_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_rd && step == 3'd2) |-> !vram_addr[0]);

  assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_pixels) |-> row_ready);

  assert_slot_top_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_ready |-> ((row_pixels & 32'h8888_8888) == 32'h0));
endmodule

bind bg_tile_fetch bgf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .restart    (restart),
  .advance    (advance),
  .step       (step_q),
  .vram_rd    (vram_rd),
  .vram_addr  (vram_addr),
  .row_pixels (row_pixels),
  .row_ready  (row_ready)
);

// File: tb/bg_tile_fetch_test.sv
module bg_tile_fetch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, restart, advance, win_mode;
  logic [7:0]  scroll_x, scroll_y, line_y, win_x, win_y_latched, fetch_x;
  logic        bg_map_sel, win_map_sel, data_area_sel;
  logic        vram_rd;
  logic [12:0] vram_addr;
  logic [7:0]  vram_rdata;
  logic [31:0] row_pixels;
  logic        row_ready;

  int n_checks = 0;
  int n_err = 0;

  logic [12:0] force_addr = 13'h0;
  logic [7:0]  force_val  = 8'h0;
  logic [7:0]  salt       = 8'h5a;

  always #(CLK_PERIOD/2) clk = ~clk;

  bg_tile_fetch uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
    .win_mode(win_mode), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .line_y(line_y), .win_x(win_x), .win_y_latched(win_y_latched),
    .fetch_x(fetch_x), .bg_map_sel(bg_map_sel), .win_map_sel(win_map_sel),
    .data_area_sel(data_area_sel), .vram_rd(vram_rd), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .row_pixels(row_pixels), .row_ready(row_ready)
  );

  function automatic logic [7:0] vdata(input logic [12:0] a);
    if (a == force_addr) return force_val;
    return (a[7:0] * 8'd37) ^ {3'b000, a[12:8]} ^ salt;
  endfunction

  always @(posedge clk) if (vram_rd) vram_rdata <= vdata(vram_addr);

  function automatic logic [7:0] exp_col();
    return win_mode ? 8'(fetch_x - win_x) : 8'(fetch_x + scroll_x);
  endfunction
  function automatic logic [7:0] exp_rowc();
    return win_mode ? 8'(line_y - win_y_latched) : 8'(line_y + scroll_y);
  endfunction
  function automatic logic [12:0] exp_map();
    logic sel;
    sel = win_mode ? win_map_sel : bg_map_sel;
    return (sel ? 13'h1800 : 13'h1C00) + 13'(exp_rowc() >> 3) * 13'd32 + 13'(exp_col() >> 3);
  endfunction
  function automatic logic [12:0] exp_base();
    logic [7:0]  t;
    logic [12:0] b;
    t = vdata(exp_map());
    if (data_area_sel) b = 13'(t) * 13'd16;
    else b = 13'(32'sh1000 + $signed({{24{t[7]}}, t}) * 16);
    return b + 13'(exp_rowc() % 8) * 13'd2;
  endfunction
  function automatic logic [31:0] exp_pix();
    logic [7:0]  lo, hi;
    logic [31:0] r;
    lo = vdata(exp_base());
    hi = vdata(exp_base() + 13'd1);
    r = '0;
    for (int i = 0; i < 8; i++)
      r[31-4*i -: 4] = {1'b0, win_mode, hi[7-i], lo[7-i]};
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input int stall_step, input int stall_len);
    @(negedge clk); restart = 1'b1; advance = 1'b1;
    @(posedge clk); @(negedge clk); restart = 1'b0; #1;
    chk("R11 no pulse after restart", 32'(row_ready), 32'd0);
    for (int k = 0; k < 6; k++) begin
      if (k == stall_step) begin
        advance = 1'b0;
        for (int s = 0; s < stall_len; s++) begin
          @(posedge clk); @(negedge clk);
          chk("R12 stall no read", 32'(vram_rd), 32'd0);
          chk("R12 stall no pulse", 32'(row_ready), 32'd0);
        end
        advance = 1'b1; #1;
      end
      case (k)
        0: begin
          chk("R2/R3/R4 map address", 32'(vram_addr), 32'(exp_map()));
          chk("R10 read at step 0", 32'(vram_rd), 32'd1);
        end
        2: begin
          chk("R5/R6/R7 low plane address", 32'(vram_addr), 32'(exp_base()));
          chk("R10 read at step 2", 32'(vram_rd), 32'd1);
        end
        4: chk("R7 high plane address", 32'(vram_addr), 32'(exp_base() + 13'd1));
        5: chk("R10 no early pulse", 32'(row_ready), 32'd0);
        default: chk("R10 no read on odd step", 32'(vram_rd), 32'd0);
      endcase
      @(posedge clk); @(negedge clk);
    end
    chk("R10 ready pulse", 32'(row_ready), 32'd1);
    chk("R8/R9 pixel row", row_pixels, exp_pix());
  endtask

  task automatic set_inputs(input logic [7:0] fx, sx, sy, ly, wx, wy,
                            input logic wm, bs, ws, ds);
    fetch_x = fx; scroll_x = sx; scroll_y = sy; line_y = ly;
    win_x = wx; win_y_latched = wy; win_mode = wm;
    bg_map_sel = bs; win_map_sel = ws; data_area_sel = ds;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; restart = 1'b0; advance = 1'b0;
    set_inputs(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 32'(row_ready), 32'd0);
    chk("R1 reset row", row_pixels, 32'd0);
    chk("R1 reset read", 32'(vram_rd), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: scroll sums wrap modulo 256
    set_inputs(8'd250, 8'd10, 8'd100, 8'd200, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    do_fetch(7, 0);
    // R3 and R4: window coordinates wrap below zero, window map bit alone picks the map
    set_inputs(8'd3, 8'd77, 8'd99, 8'd5, 8'd7, 8'd9, 1'b1, 1'b0, 1'b1, 1'b1);
    do_fetch(7, 0);
    // R6: signed tile numbers at both extremes
    set_inputs(8'd40, 8'd0, 8'd3, 8'd18, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    force_addr = exp_map(); force_val = 8'h80;
    do_fetch(7, 0);
    force_val = 8'h7f;
    do_fetch(7, 0);
    // R5: largest unsigned tile number
    data_area_sel = 1'b1; force_val = 8'hff;
    do_fetch(7, 0);
    // R10: wrap to a second fetch with advance held high
    for (int e = 1; e <= 8; e++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 wrap pulse timing", 32'(row_ready), (e == 8) ? 32'd1 : 32'd0);
    end
    chk("R10 wrapped row", row_pixels, exp_pix());
    // R11: abandon a fetch part way, then fetch with new inputs
    @(negedge clk); restart = 1'b1;
    @(posedge clk); @(negedge clk); restart = 1'b0;
    repeat (3) @(posedge clk);
    set_inputs(8'd128, 8'd8, 8'd16, 8'd31, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_fetch(7, 0);
    // R12: stalls at each step
    for (int s = 0; s < 6; s++) do_fetch(s, 2);

    for (int it = 0; it < 40; it++) begin
      set_inputs(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
      salt = 8'($urandom);
      do_fetch(int'($urandom % 9), int'($urandom % 3) + 1);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule